// File: doc/BRIEF.md
# Latch-up Protection Power Controller

This controller sits beside an external current-sense comparator and guards one supply rail that feeds a device prone to single-event latch-up. While the rail is in service it watches the comparator's overcurrent flag. A qualified overcurrent opens the series power switch, because cutting the supply is what clears a latch. After one dead cycle with both switches off, it closes a parallel crowbar switch that drains the charge left on the rail. Once the rail has stayed off for a set time, the controller brings power back by itself. It does not wait for software.

The flag arrives from another timing domain. It passes through a synchronizer and must stay high for a set number of consecutive cycles before it counts as a trip, so single-cycle glitches are rejected. For a set period after each power-up the flag is ignored, because inrush current at switch-on would otherwise look like a latch event. Telemetry reads the current state code, a saturating event counter and a sticky event flag. Software clears the sticky flag with a one-cycle pulse.

The states and transitions are:
- OFF goes to POWER_ON on a high software enable.
- POWER_ON (blanking) goes to RUN when the blanking time expires, or to OFF when the enable drops.
- RUN goes to TRIP on a qualified overcurrent, or to OFF when the enable drops.
- TRIP (dead cycle) always goes to CROWBAR.
- CROWBAR goes to HOLDOFF when the crowbar time expires.
- HOLDOFF goes to POWER_ON when the off time expires and the enable is high, or to OFF when the enable is low.

Top module: `lu_guard`

## Requirements
- R1: While rst_n is low and in the cycle after it is released, power_enable and crowbar_enable are 0, state_code is 0 (OFF), event_count is 0 and sticky_flag is 0.
- R2: The state_code values are OFF=0, POWER_ON=1, RUN=2, TRIP=3, CROWBAR=4 and HOLDOFF=5. With sw_enable high in OFF, the next cycle shows POWER_ON with power_enable=1. With sw_enable low, OFF is kept.
- R3: POWER_ON lasts exactly BLANK_CYCLES cycles with power_enable=1, then RUN follows. latch_detect is ignored throughout POWER_ON, so a flag that falls before RUN begins causes no trip.
- R4: In RUN, suppose latch_detect is first sampled high at rising edge k and held, and the state is RUN from edge k+2 on. Then TRIP is entered at edge k+GLITCH_CYCLES+1, with power_enable=0.
- R5: A latch_detect pulse sampled high at only GLITCH_CYCLES-1 consecutive edges causes no trip.
- R6: TRIP lasts one cycle with both power_enable and crowbar_enable low. Then crowbar_enable is 1 for exactly CROWBAR_CYCLES cycles in CROWBAR. power_enable and crowbar_enable are never both 1.
- R7: HOLDOFF keeps both outputs low for exactly OFF_CYCLES cycles. It then goes to POWER_ON if sw_enable is high, or to OFF if it is low.
- R8: sw_enable low in POWER_ON or RUN gives OFF in the next cycle. sw_enable has no effect in TRIP or CROWBAR.
- R9: event_count rises by one in the same cycle TRIP first shows. It saturates at all ones (255 at CNT_W=8).
- R10: sticky_flag is set in the cycle TRIP first shows. A sticky_clr pulse clears it in the next cycle. When a set and a clear meet in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| latch_detect | input | 1 | Overcurrent flag from the comparator (asynchronous) |
| sw_enable | input | 1 | Software request to power the rail |
| sticky_clr | input | 1 | Write-one pulse clearing sticky_flag |
| power_enable | output | 1 | Closes the series supply switch |
| crowbar_enable | output | 1 | Closes the rail discharge switch |
| state_code | output | 3 | Current state code (see R2) |
| event_count | output | CNT_W | Saturating trip counter |
| sticky_flag | output | 1 | Set on a trip, held until cleared |

## Verification
The bench builds the block with a blanking time of 6, a crowbar time of 4, an off time of 5 and a qualification length of 3, leaving the synchronizer depth and counter width at their defaults. With these short windows, every state boundary of a whole trip-and-recover round can be checked cycle by cycle. The round takes 22 cycles, so the bench can run 256 trips in a few thousand cycles and drive the 8-bit counter into saturation. The short values also allow the corner cases to be exercised in isolation: a flag hidden inside blanking, a pulse one cycle too short, an enable drop during the crowbar phase, and a set that coincides with a clear.

// File: rtl/lu_guard_pkg.sv
package lu_guard_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_PWR_ON  = 3'd1,
        ST_RUN     = 3'd2,
        ST_TRIP    = 3'd3,
        ST_CROWBAR = 3'd4,
        ST_HOLDOFF = 3'd5
    } guard_state_t;

endpackage

// File: rtl/lu_sync.sv
module lu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[i] <= 1'b0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/lu_qualify.sv
module lu_qualify #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic level,
    output logic hit
);

    localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!armed || !level) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign hit = armed && level && (run_q == LAST);

endmodule

// File: rtl/lu_status.sv
module lu_status #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             sticky
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky <= 1'b0;
        end else if (bump) begin
            sticky <= 1'b1;
        end else if (clr) begin
            sticky <= 1'b0;
        end
    end

endmodule

// File: rtl/lu_guard.sv
module lu_guard
    import lu_guard_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int GLITCH_CYCLES  = 3,
    parameter int BLANK_CYCLES   = 16,
    parameter int CROWBAR_CYCLES = 8,
    parameter int OFF_CYCLES     = 32,
    parameter int CNT_W          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_detect,
    input  logic             sw_enable,
    input  logic             sticky_clr,
    output logic             power_enable,
    output logic             crowbar_enable,
    output logic [2:0]       state_code,
    output logic [CNT_W-1:0] event_count,
    output logic             sticky_flag
);

    localparam int MAX_A  = (BLANK_CYCLES > CROWBAR_CYCLES) ? BLANK_CYCLES : CROWBAR_CYCLES;
    localparam int MAX_D  = (MAX_A > OFF_CYCLES) ? MAX_A : OFF_CYCLES;
    localparam int TMR_W  = $clog2(MAX_D) + 1;
    localparam logic [TMR_W-1:0] LD_BLANK = TMR_W'(BLANK_CYCLES - 1);
    localparam logic [TMR_W-1:0] LD_CBAR  = TMR_W'(CROWBAR_CYCLES - 1);
    localparam logic [TMR_W-1:0] LD_OFF   = TMR_W'(OFF_CYCLES - 1);

    guard_state_t     state_q, state_nxt;
    logic [TMR_W-1:0] timer_q, timer_ld;
    logic             tmr_done;
    logic             flag_sync;
    logic             trip_hit;
    logic             enter_trip;

    // flag into this clock domain
    lu_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (latch_detect),
        .q_sync  (flag_sync)
    );

    // consecutive-high qualifier, armed only while the rail is in service
    lu_qualify #(.RUN_LEN(GLITCH_CYCLES)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (state_q == ST_RUN),
        .level (flag_sync),
        .hit   (trip_hit)
    );

    assign enter_trip = (state_q == ST_RUN) && trip_hit;

    lu_status #(.CNT_W(CNT_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .bump   (enter_trip),
        .clr    (sticky_clr),
        .count  (event_count),
        .sticky (sticky_flag)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nxt;
    end

    // dwell timer, reloaded on every state change
    always_comb begin
        unique case (state_nxt)
            ST_PWR_ON:  timer_ld = LD_BLANK;
            ST_CROWBAR: timer_ld = LD_CBAR;
            ST_HOLDOFF: timer_ld = LD_OFF;
            default:    timer_ld = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
        end else if (state_nxt != state_q) begin
            timer_q <= timer_ld;
        end else if (timer_q != '0) begin
            timer_q <= timer_q - 1'b1;
        end
    end

    assign tmr_done = (timer_q == '0);

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (sw_enable) state_nxt = ST_PWR_ON;
            end
            ST_PWR_ON: begin
                if (!sw_enable)    state_nxt = ST_OFF;
                else if (tmr_done) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (trip_hit)        state_nxt = ST_TRIP;
                else if (!sw_enable) state_nxt = ST_OFF;
            end
            ST_TRIP: begin
                state_nxt = ST_CROWBAR;
            end
            ST_CROWBAR: begin
                if (tmr_done) state_nxt = ST_HOLDOFF;
            end
            ST_HOLDOFF: begin
                if (tmr_done) state_nxt = sw_enable ? ST_PWR_ON : ST_OFF;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        power_enable   = 1'b0;
        crowbar_enable = 1'b0;
        unique case (state_q)
            ST_PWR_ON, ST_RUN: power_enable   = 1'b1;
            ST_CROWBAR:        crowbar_enable = 1'b1;
            default: ;
        endcase
    end

    assign state_code = state_q;

endmodule

// File: rtl/lu_guard_chk.sv
module lu_guard_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             power_enable,
    input logic             crowbar_enable,
    input logic [2:0]       state_code,
    input logic [CNT_W-1:0] event_count,
    input logic             sticky_flag
);

    // R6
    switch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(power_enable && crowbar_enable))
        else $error("series switch and crowbar both on");

    // R6
    dead_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crowbar_enable) |-> ($past(state_code) == 3'd3 && !$past(power_enable)))
        else $error("crowbar not preceded by dead cycle");

    // R7
    holdoff_after_cbar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crowbar_enable) |-> (state_code == 3'd5))
        else $error("crowbar release not into holdoff");

    // R3
    power_via_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_enable) |-> (state_code == 3'd1))
        else $error("power restored without blanking");

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_count != $past(event_count)) |->
        ((event_count - $past(event_count)) == CNT_W'(1)))
        else $error("event counter moved by more than one");

    // R9
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(event_count) == {CNT_W{1'b1}}) |-> (event_count == {CNT_W{1'b1}}))
        else $error("event counter wrapped");

    // R10
    sticky_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_flag) |-> (state_code == 3'd3))
        else $error("sticky flag set outside a trip");

endmodule

bind lu_guard lu_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .power_enable   (power_enable),
    .crowbar_enable (crowbar_enable),
    .state_code     (state_code),
    .event_count    (event_count),
    .sticky_flag    (sticky_flag)
);

// File: tb/lu_guard_tb.sv
`timescale 1ns/1ps
module lu_guard_tb;

    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic latch_detect = 1'b0;
    logic sw_enable = 1'b0;
    logic sticky_clr = 1'b0;
    logic power_enable, crowbar_enable, sticky_flag;
    logic [2:0] state_code;
    logic [CNT_W-1:0] event_count;

    always #5 clk = ~clk;

    lu_guard #(
        .SYNC_STAGES(2), .GLITCH_CYCLES(3), .BLANK_CYCLES(6),
        .CROWBAR_CYCLES(4), .OFF_CYCLES(5), .CNT_W(CNT_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .latch_detect(latch_detect),
        .sw_enable(sw_enable), .sticky_clr(sticky_clr),
        .power_enable(power_enable), .crowbar_enable(crowbar_enable),
        .state_code(state_code), .event_count(event_count),
        .sticky_flag(sticky_flag)
    );

    typedef struct {
        int          cyc;
        bit          pw;
        bit          cb;
        int          st;
        int          cnt;
        bit          sk;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    int   exp_cnt = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int dcy, input bit pw, input bit cb,
                             input int st, input int cnt, input bit sk,
                             input string tag);
        exp_t e;
        e.cyc = cyc + dcy; e.pw = pw; e.cb = cb; e.st = st;
        e.cnt = cnt; e.sk = sk; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: compare scoreboard entries that fall due in this cycle
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (e.cyc != cyc || power_enable !== e.pw || crowbar_enable !== e.cb ||
                int'(state_code) != e.st || int'(event_count) != e.cnt ||
                sticky_flag !== e.sk) begin
                bad++;
                $display("FAIL %s @%0d: got pw=%0b cb=%0b st=%0d cnt=%0d sk=%0b exp pw=%0b cb=%0b st=%0d cnt=%0d sk=%0b",
                         e.tag, e.cyc, power_enable, crowbar_enable, state_code,
                         event_count, sticky_flag, e.pw, e.cb, e.st, e.cnt, e.sk);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        expect_at(1, 0, 0, 0, 0, 0, "R1 in reset");
        step(1);
        rst_n = 1'b1;
        expect_at(1, 0, 0, 0, 0, 0, "R1 after release");
        expect_at(2, 0, 0, 0, 0, 0, "R2 idle without enable");
        step(3);

        // power up with the flag high inside blanking only
        sw_enable = 1'b1;
        latch_detect = 1'b1;
        expect_at(1, 1, 0, 1, 0, 0, "R2 power on");
        expect_at(6, 1, 0, 1, 0, 0, "R3 last blank cycle");
        expect_at(7, 1, 0, 2, 0, 0, "R3 run after blank");
        expect_at(12, 1, 0, 2, 0, 0, "R3 blanked flag ignored");
        step(4);
        latch_detect = 1'b0;
        step(9);

        // pulse one cycle short of qualification
        latch_detect = 1'b1;
        step(2);
        latch_detect = 1'b0;
        expect_at(6, 1, 0, 2, 0, 0, "R5 short pulse no trip");
        step(8);

        // full trip and automatic recovery
        latch_detect = 1'b1;
        exp_cnt = 1;
        expect_at(4, 1, 0, 2, 0, 0, "R4 not yet tripped");
        expect_at(5, 0, 0, 3, exp_cnt, 1, "R4 R6 R9 R10 trip dead cycle");
        expect_at(6, 0, 1, 4, exp_cnt, 1, "R6 crowbar on");
        expect_at(9, 0, 1, 4, exp_cnt, 1, "R6 crowbar last");
        expect_at(10, 0, 0, 5, exp_cnt, 1, "R7 holdoff");
        expect_at(14, 0, 0, 5, exp_cnt, 1, "R7 holdoff last");
        expect_at(15, 1, 0, 1, exp_cnt, 1, "R7 repower");
        expect_at(21, 1, 0, 2, exp_cnt, 1, "R3 run after repower");
        step(6);
        latch_detect = 1'b0;
        step(16);

        // sticky clear
        sticky_clr = 1'b1;
        expect_at(1, 1, 0, 2, exp_cnt, 0, "R10 sticky cleared");
        step(1);
        sticky_clr = 1'b0;
        step(2);

        // enable drop in run
        sw_enable = 1'b0;
        expect_at(1, 0, 0, 0, exp_cnt, 0, "R8 off from run");
        step(3);
        sw_enable = 1'b1;
        expect_at(7, 1, 0, 2, exp_cnt, 0, "R2 run again");
        step(8);

        // enable drop during crowbar is ignored, holdoff then goes off
        latch_detect = 1'b1;
        exp_cnt = 2;
        expect_at(5, 0, 0, 3, exp_cnt, 1, "R4 second trip");
        step(6);
        latch_detect = 1'b0;
        sw_enable = 1'b0;
        expect_at(3, 0, 1, 4, exp_cnt, 1, "R8 enable ignored in crowbar");
        expect_at(8, 0, 0, 5, exp_cnt, 1, "R7 holdoff end");
        expect_at(9, 0, 0, 0, exp_cnt, 1, "R7 holdoff to off");
        step(10);

        // set beats clear
        sw_enable = 1'b1;
        step(8);
        latch_detect = 1'b1;
        sticky_clr = 1'b1;
        expect_at(1, 1, 0, 2, exp_cnt, 0, "R10 clear before trip");
        step(1);
        sticky_clr = 1'b0;
        step(3);
        sticky_clr = 1'b1;
        exp_cnt = 3;
        expect_at(1, 0, 0, 3, exp_cnt, 1, "R10 set wins over clear");
        step(1);
        sticky_clr = 1'b0;
        step(1);
        latch_detect = 1'b0;
        step(16);

        // saturation
        for (int i = 0; i < 253; i++) begin
            latch_detect = 1'b1;
            step(6);
            latch_detect = 1'b0;
            step(16);
            if (exp_cnt < 255) exp_cnt++;
        end
        expect_at(1, 1, 0, 2, 255, 1, "R9 counter saturated");
        step(3);

        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard left %0d entries, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule